// File: doc/BRIEF.md
# Segment Override Resolver

This block chooses which of six segment registers supplies the base of a data access and forms the physical address for a given offset. As the current instruction is decoded, a prefix decoder raises one-hot strobes that set override bits. Address generation raises a separate strobe when the addressing form defaults to the stack segment. The block keeps these bits for the whole instruction. With no override it selects the data segment, or the stack segment when the stack-default bit is set. A single override always wins. Two or more overrides at once are an illegal state, and the block reports it on a sticky halt output.

At the end of each instruction the control issues a clear that empties every override bit and the stack-default bit. The clear is skipped when the instruction that just finished was a segment-prefix byte, so the override it recorded carries over to the instruction that follows. The physical address is the selected segment shifted left by four bits plus the offset, kept to 20 bits.

Top module: `segres_top`

## Requirements
- R1: After reset, no override bit or stack-default bit is held, `halt` and `clrDone` are low, and `segOut` equals `segDs`.
- R2: With no override held and the stack-default bit clear, `segOut` equals `segDs`.
- R3: With no override held and the stack-default bit set, `segOut` equals `segSs`.
- R4: With exactly one override bit held, `segOut` is that register, whatever the stack-default bit holds. The bit map of `ovrSet` is: bit 0 CS, bit 1 DS, bit 2 ES, bit 3 FS, bit 4 GS, bit 5 SS.
- R5: `physAddr` equals (`segOut` * 16 + `offset`) modulo 2^20, so the carry out of bit 19 is lost.
- R6: When two or more override bits are held, `halt` goes high at the next clock edge. While the held state is illegal, `segOut` is zero.
- R7: Once high, `halt` stays high until reset, including after the override bits have been cleared.
- R8: Set strobes (`ovrSet` bits, `ssDefSet`) are ORed into the held state at a clock edge. Their effect shows in the following cycle.
- R9: `instrEnd` high with `prefixEnd` low empties the held state at that edge. Any set strobes present in the same cycle are still applied after the clear.
- R10: `instrEnd` high with `prefixEnd` high leaves every held bit in place.
- R11: `clrDone` is high for exactly the one cycle that follows each edge at which a clear took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ovrSet | input | 6 | One-hot override set strobes (0 CS, 1 DS, 2 ES, 3 FS, 4 GS, 5 SS) |
| ssDefSet | input | 1 | Sets the stack-default bit |
| instrEnd | input | 1 | Current instruction is finishing |
| prefixEnd | input | 1 | The finishing instruction is a segment prefix |
| segCs | input | 16 | Code segment value |
| segDs | input | 16 | Data segment value |
| segEs | input | 16 | Extra segment value |
| segFs | input | 16 | F segment value |
| segGs | input | 16 | G segment value |
| segSs | input | 16 | Stack segment value |
| offset | input | 16 | Access offset |
| segOut | output | 16 | Selected segment value |
| physAddr | output | 20 | Physical address |
| halt | output | 1 | Sticky illegal-override flag |
| clrDone | output | 1 | One-cycle pulse after a clear |

## Verification
Some behaviours are checked by assertions on every cycle. These are: the halt response to a multi-override state and halt staying high; the held state being empty after a clear that has no simultaneous sets; prefix ends keeping every held bit; and `clrDone` appearing only after a real clear. Other behaviours can only be shown by the bench scenarios, which compare against the reference model. These are: the selection of each of the six registers under both default settings, the wrap of the address at 20 bits, sets that arrive in the same cycle as a clear, and halt being released only by reset.

// File: rtl/segres_pkg.sv
package segres_pkg;
  localparam int NUM_SEG = 6;
  localparam int IDX_CS = 0;
  localparam int IDX_DS = 1;
  localparam int IDX_ES = 2;
  localparam int IDX_FS = 3;
  localparam int IDX_GS = 4;
  localparam int IDX_SS = 5;

  typedef struct packed {
    logic clr;
    logic ovrLd;
    logic defLd;
  } segres_strb_t;
endpackage

// File: rtl/segres_ctrl.sv
module segres_ctrl
  import segres_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrEnd,
  input  logic               prefixEnd,
  input  logic [NUM_SEG-1:0] ovrSet,
  input  logic               ssDefSet,
  input  logic               multiOvr,
  output segres_strb_t       strb,
  output logic               haltQ,
  output logic               clrDoneQ
);
  always_comb begin
    strb.clr   = instrEnd & ~prefixEnd;
    strb.ovrLd = |ovrSet;
    strb.defLd = ssDefSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ    <= 1'b0;
      clrDoneQ <= 1'b0;
    end else begin
      haltQ    <= haltQ | multiOvr;
      clrDoneQ <= strb.clr;
    end
  end

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    clrDoneQ |-> $past(instrEnd && !prefixEnd)); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ); // R7
endmodule

// File: rtl/segres_dp.sv
module segres_dp
  import segres_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  segres_strb_t                    strb,
  input  logic [NUM_SEG-1:0]              ovrSet,
  input  logic [NUM_SEG-1:0][SEG_W-1:0]   segVals,
  input  logic [OFF_W-1:0]                offset,
  output logic [SEG_W-1:0]                segOut,
  output logic [ADDR_W-1:0]               physAddr,
  output logic                            multiOvr,
  output logic [NUM_SEG-1:0]              ovrQ,
  output logic                            defQ
);
  localparam int SH_W = SEG_W + SHIFT;

  logic [NUM_SEG-1:0] ovrBase;
  logic               defBase;
  logic [NUM_SEG-1:0][SEG_W-1:0] masked;
  logic [SEG_W-1:0]   ovrPick;
  logic [SH_W-1:0]    shifted;

  // Clear first, then OR in this cycle's sets.
  always_comb begin
    ovrBase = strb.clr ? '0 : ovrQ;
    defBase = strb.clr ? 1'b0 : defQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrQ <= '0;
      defQ <= 1'b0;
    end else begin
      ovrQ <= strb.ovrLd ? (ovrBase | ovrSet) : ovrBase;
      defQ <= defBase | strb.defLd;
    end
  end

  assign multiOvr = |(ovrQ & (ovrQ - NUM_SEG'(1)));

  for (genvar g = 0; g < NUM_SEG; g++) begin : gMask
    assign masked[g] = segVals[g] & {SEG_W{ovrQ[g]}};
  end

  always_comb begin
    ovrPick = '0;
    for (int i = 0; i < NUM_SEG; i++) ovrPick = ovrPick | masked[i];
  end

  always_comb begin
    if (multiOvr)           segOut = '0;
    else if (ovrQ != '0)    segOut = ovrPick;
    else if (defQ)          segOut = segVals[IDX_SS];
    else                    segOut = segVals[IDX_DS];
  end

  assign shifted  = {segOut, {SHIFT{1'b0}}};
  assign physAddr = ADDR_W'(shifted) + ADDR_W'(offset);

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && !strb.ovrLd && !strb.defLd) |=> (ovrQ == '0 && !defQ)); // R9
  AST_DS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (ovrQ == '0 && !defQ) |-> segOut == segVals[IDX_DS]); // R2
endmodule

// File: rtl/segres_top.sv
module segres_top
  import segres_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEG-1:0] ovrSet,
  input  logic               ssDefSet,
  input  logic               instrEnd,
  input  logic               prefixEnd,
  input  logic [SEG_W-1:0]   segCs,
  input  logic [SEG_W-1:0]   segDs,
  input  logic [SEG_W-1:0]   segEs,
  input  logic [SEG_W-1:0]   segFs,
  input  logic [SEG_W-1:0]   segGs,
  input  logic [SEG_W-1:0]   segSs,
  input  logic [OFF_W-1:0]   offset,
  output logic [SEG_W-1:0]   segOut,
  output logic [ADDR_W-1:0]  physAddr,
  output logic               halt,
  output logic               clrDone
);
  segres_strb_t strb;
  logic multiOvr;
  logic defQ;
  logic [NUM_SEG-1:0] ovrQ;
  logic [NUM_SEG-1:0][SEG_W-1:0] segVals;

  always_comb begin
    segVals[IDX_CS] = segCs;
    segVals[IDX_DS] = segDs;
    segVals[IDX_ES] = segEs;
    segVals[IDX_FS] = segFs;
    segVals[IDX_GS] = segGs;
    segVals[IDX_SS] = segSs;
  end

  segres_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .prefixEnd(prefixEnd),
    .ovrSet(ovrSet), .ssDefSet(ssDefSet), .multiOvr(multiOvr),
    .strb(strb), .haltQ(halt), .clrDoneQ(clrDone)
  );

  segres_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ovrSet(ovrSet), .segVals(segVals),
    .offset(offset), .segOut(segOut), .physAddr(physAddr), .multiOvr(multiOvr),
    .ovrQ(ovrQ), .defQ(defQ)
  );

  AST_MULTI_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(ovrQ) > 1) |=> halt); // R6
  AST_PREFIX_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (instrEnd && prefixEnd) |=> ((ovrQ & $past(ovrQ)) == $past(ovrQ))); // R10
endmodule

// File: tb/segres_top_tb.sv
module segres_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] ovrSet = '0;
  logic ssDefSet = 1'b0, instrEnd = 1'b0, prefixEnd = 1'b0;
  logic [15:0] segCs = 16'h1234, segDs = 16'h2000, segEs = 16'h3A00;
  logic [15:0] segFs = 16'h4B10, segGs = 16'h5C20, segSs = 16'hFFFF;
  logic [15:0] offset = 16'h0010;
  logic [15:0] segOut;
  logic [19:0] physAddr;
  logic halt, clrDone;

  int errors = 0, checks = 0;
  string curReq = "R1";

  // reference model state
  logic [5:0] mOvr;
  logic mDef, mHalt, mClr;

  always #4 clk = ~clk;

  segres_top u_dut (
    .clk(clk), .rstN(rstN), .ovrSet(ovrSet), .ssDefSet(ssDefSet),
    .instrEnd(instrEnd), .prefixEnd(prefixEnd), .segCs(segCs), .segDs(segDs),
    .segEs(segEs), .segFs(segFs), .segGs(segGs), .segSs(segSs),
    .offset(offset), .segOut(segOut), .physAddr(physAddr), .halt(halt),
    .clrDone(clrDone)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOvr = '0; mDef = 0; mHalt = 0; mClr = 0;
    end else begin
      if ($countones(mOvr) > 1) mHalt = 1;
      mClr = instrEnd && !prefixEnd;
      mOvr = (mClr ? 6'b0 : mOvr) | ovrSet;
      mDef = (mClr ? 1'b0 : mDef) | ssDefSet;
    end
  end

  function automatic logic [15:0] expSeg();
    logic [15:0] arr [6];
    arr[0] = segCs; arr[1] = segDs; arr[2] = segEs;
    arr[3] = segFs; arr[4] = segGs; arr[5] = segSs;
    if (mOvr == 0) return mDef ? segSs : segDs;
    if ($countones(mOvr) > 1) return 16'h0;
    for (int i = 0; i < 6; i++) if (mOvr[i]) return arr[i];
    return 16'h0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      int es;
      es = int'(expSeg());
      check(curReq, "segOut", int'(segOut), es);
      check((curReq == "R2" || curReq == "R3") ? curReq : "R5", "physAddr",
            int'(physAddr), ((es * 16) + int'(offset)) % (1 << 20));
      check((mHalt || curReq == "R6") ? "R7" : curReq, "halt", int'(halt), int'(mHalt));
      check("R11", "clrDone", int'(clrDone), int'(mClr));
    end
  end

  task automatic step(input logic [5:0] s, input logic d, input logic e, input logic p,
                      input logic [15:0] off);
    @(negedge clk); #1;
    ovrSet = s; ssDefSet = d; instrEnd = e; prefixEnd = p; offset = off;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(6'b0, 0, 0, 0, offset);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curReq = "R1";
    idle(2);
    curReq = "R2";
    step(0, 0, 0, 0, 16'h0000); step(0, 0, 0, 0, 16'hABCD); idle(1);
    curReq = "R3";
    step(0, 1, 0, 0, 16'h0042); idle(2);
    curReq = "R9";
    step(0, 0, 1, 0, 16'h0042); idle(2);
    curReq = "R4";
    for (int i = 0; i < 6; i++) begin
      step(6'(1 << i), i[0], 0, 0, 16'(i * 16'h111)); idle(2);
      step(0, 0, 1, 0, offset); idle(1);
    end
    curReq = "R5";
    step(6'b100000, 0, 0, 0, 16'hFFFF); idle(2);
    step(0, 0, 1, 0, 16'h0011); idle(1);
    curReq = "R10";
    step(6'b000100, 0, 1, 1, 16'h0020); idle(1);
    step(0, 1, 0, 0, 16'h0020); idle(2);
    step(0, 0, 1, 0, 16'h0020); idle(1);
    curReq = "R9";
    step(6'b010000, 1, 1, 0, 16'h0030); idle(2);
    step(0, 0, 1, 0, 16'h0030); idle(1);
    curReq = "R8";
    step(0, 1, 0, 0, 16'h0040); idle(1);
    step(6'b000001, 0, 0, 0, 16'h0040); idle(2);
    step(0, 0, 1, 0, 16'h0040); idle(1);
    curReq = "R6";
    step(6'b001001, 0, 0, 0, 16'h0050); idle(3);
    curReq = "R7";
    step(0, 0, 1, 0, 16'h0050); idle(3);
    step(6'b000010, 0, 0, 0, 16'h0060); idle(2);
    @(negedge clk); #1 rstN = 1'b0;
    idle(2);
    @(negedge clk); #1 rstN = 1'b1;
    curReq = "R1";
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule